// File: doc/BRIEF.md
# Ratiometric Conversion and Fault-Status Controller

This block sequences conversions for a 15-bit ratiometric resistance converter and manages what happens to each result. It does not model the modulator or the filter arithmetic. An ADC stub presents a raw 15-bit sample. The controller decides when that sample becomes a stored result, and how long each conversion lasts for the selected notch (50 Hz or 60 Hz). It stores the result together with a summary fault flag, compares it with two programmable limits, keeps a sticky fault-status byte, and drives an active-low data-ready line.

The host side arrives already decoded:
- A configuration-byte write strobe.
- A threshold write port that selects the high or the low limit.
- A one-cycle pulse when the chip-select transaction ends.
- A one-cycle pulse when the result registers are read.
- A level that reports an over- or under-voltage condition on the sensor pins.

A four-state machine runs the timing:
- `S_IDLE` waits for work.
- `S_SINGLE` runs one triggered conversion.
- `S_FIRST` runs the first, long conversion after continuous mode is entered.
- `S_REPEAT` runs each later continuous period.

The transitions are as follows:
- `S_IDLE` to `S_FIRST` when the mode bit is set.
- `S_IDLE` to `S_SINGLE` on an armed end-of-transaction.
- `S_SINGLE` to `S_IDLE` on timer expiry.
- `S_FIRST` or `S_REPEAT` to `S_REPEAT` on expiry while the mode bit stays set.
- `S_FIRST` or `S_REPEAT` to `S_IDLE` as soon as the mode bit is cleared. This abandons the conversion in flight.

Top module: `rtd_conv_ctrl`

## Requirements
- R1: After reset, `result_o` is 0, `status_o` is 0 and `drdy_n_o` is 1. The high limit resets to all ones and the low limit resets to zero, so a full-scale sample sets only status bit 7 and a zero sample sets only status bit 6.
- R2: A configuration write with bit 5 = 1 and bits 3:2 = 00 arms a one-shot. The arm holds across further writes and is consumed by `xfer_end_i`. The conversion starts on the edge that samples `xfer_end_i`. Without that pulse no conversion starts.
- R3: A triggered conversion stores its result `ONE60` clock edges after the start edge when configuration bit 0 = 0, and `ONE50` edges after it when bit 0 = 1. Data-ready is still high one edge earlier.
- R4: Writing configuration bit 6 = 1 starts continuous mode. The first result lands `ONE60`/`ONE50` edges after the edge that first sees the mode bit, and later results follow every `CONT60`/`CONT50` edges. Writing bit 6 = 0 stops conversions, and no further result is stored.
- R5: `result_o[15:1]` holds the stored 15-bit sample. `result_o[0]` is 1 exactly when any of status bits 7:2 is set.
- R6: A stored sample that is greater than or equal to the high limit sets status bit 7. A stored sample that is less than or equal to the low limit sets status bit 6. A threshold write takes `thr_data_i[15:1]` and ignores bit 0. `thr_sel_i` = 0 selects the high limit and 1 selects the low limit.
- R7: While `pin_fault_i` is 1, status bit 2 is set from the next edge on. Completed conversions then store nothing and leave data-ready untouched. Storing resumes once the flag drops.
- R8: Status bits stay set until a configuration write with bit 1 = 1 and bits 5, 3 and 2 all 0. Any other clear attempt is ignored. Bit 2 sets again on the clearing edge if the pin fault is still present.
- R9: `drdy_n_o` falls on the edge that stores a result. It stays low until a `res_rd_i` pulse and rises on the edge after that pulse.
- R10: A one-shot armed and released while a conversion is running is discarded. It produces no later conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Configuration byte write strobe |
| cfg_data_i | input | 8 | Configuration byte: 6 continuous, 5 one-shot, 3:2 cycle field, 1 clear, 0 notch 50 Hz |
| thr_wr_i | input | 1 | Threshold write strobe |
| thr_sel_i | input | 1 | 0 high limit, 1 low limit |
| thr_data_i | input | 16 | Limit in bits 15:1, bit 0 ignored |
| xfer_end_i | input | 1 | Pulse at chip-select release ending a transaction |
| res_rd_i | input | 1 | Pulse when the result registers are read |
| pin_fault_i | input | 1 | Over/under-voltage on sensor pins (level) |
| adc_sample_i | input | 15 | Raw sample from the converter stub |
| result_o | output | 16 | Stored sample in 15:1, summary fault in 0 |
| status_o | output | 8 | Sticky faults: 7 high limit, 6 low limit, 2 pin fault |
| drdy_n_o | output | 1 | Active-low data ready |

## Verification
The hardest situation to reach is a one-shot request that lands while a conversion is already running. From the ports it looks exactly like a legal request, and a wrong design would only show a spurious second result a full conversion time later. The bench starts a conversion, re-arms and releases mid-flight, and then watches data-ready for longer than one conversion after the real result has been read. The pin-fault freeze is reached the same way: the flag is held through a complete triggered conversion, and the bench confirms that neither the result nor data-ready moved.

// File: rtl/rtd_conv_pkg.sv
package rtd_conv_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SINGLE = 2'd1,
        S_FIRST  = 2'd2,
        S_REPEAT = 2'd3
    } conv_state_e;

    // configuration byte bit positions
    localparam int CFG_CONT    = 6;
    localparam int CFG_ONESHOT = 5;
    localparam int CFG_CYC_HI  = 3;
    localparam int CFG_CYC_LO  = 2;
    localparam int CFG_CLR     = 1;
    localparam int CFG_NOTCH50 = 0;

    // status byte bit positions
    localparam int ST_HIGH = 7;
    localparam int ST_LOW  = 6;
    localparam int ST_PIN  = 2;

endpackage

// File: rtl/conv_timer.sv
module conv_timer #(
    parameter int CW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] len_i,
    output logic          done_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // last cycle of the window: the consumer acts on the following edge
    assign done_o = (cnt_q == CW'(1));

endmodule

// File: rtl/thr_regs.sv
module thr_regs #(
    parameter int DW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic          sel_i,
    input  logic [DW:0]   data_i,
    output logic [DW-1:0] hi_o,
    output logic [DW-1:0] lo_o
);
    localparam int NREG = 2;

    logic [DW-1:0] lim_q [NREG];
    logic          unused_lsb;

    assign unused_lsb = data_i[0];

    for (genvar g = 0; g < NREG; g++) begin : g_lim
        // entry 0 is the high limit (resets to full scale), entry 1 the low limit
        localparam logic [DW-1:0] RST_VAL = (g == 0) ? {DW{1'b1}} : {DW{1'b0}};
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lim_q[g] <= RST_VAL;
            end else if (wr_i && (sel_i == g[0])) begin
                lim_q[g] <= data_i[DW:1];
            end
        end
    end

    assign hi_o = lim_q[0];
    assign lo_o = lim_q[1];

endmodule

// File: rtl/fault_status.sv
module fault_status
    import rtd_conv_pkg::*;
#(
    parameter int DW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          store_i,
    input  logic [DW-1:0] sample_i,
    input  logic [DW-1:0] hi_i,
    input  logic [DW-1:0] lo_i,
    input  logic          pin_fault_i,
    input  logic          clr_i,
    output logic [7:0]    status_o
);
    logic [7:0] status_q;
    logic [7:0] set_v;

    always_comb begin
        set_v          = '0;
        set_v[ST_HIGH] = store_i && (sample_i >= hi_i);
        set_v[ST_LOW]  = store_i && (sample_i <= lo_i);
        set_v[ST_PIN]  = pin_fault_i;
    end

    // new events win over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (clr_i) begin
            status_q <= set_v;
        end else begin
            status_q <= status_q | set_v;
        end
    end

    assign status_o = status_q;

endmodule

// File: rtl/rtd_conv_ctrl.sv
module rtd_conv_ctrl
    import rtd_conv_pkg::*;
#(
    parameter int DW     = 15,
    parameter int ONE60  = 520000,
    parameter int ONE50  = 625000,
    parameter int CONT60 = 167000,
    parameter int CONT50 = 200000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr_i,
    input  logic [7:0]    cfg_data_i,
    input  logic          thr_wr_i,
    input  logic          thr_sel_i,
    input  logic [DW:0]   thr_data_i,
    input  logic          xfer_end_i,
    input  logic          res_rd_i,
    input  logic          pin_fault_i,
    input  logic [DW-1:0] adc_sample_i,
    output logic [DW:0]   result_o,
    output logic [7:0]    status_o,
    output logic          drdy_n_o
);
    localparam int MAX_A  = (ONE60 > ONE50) ? ONE60 : ONE50;
    localparam int MAX_B  = (CONT60 > CONT50) ? CONT60 : CONT50;
    localparam int MAXLEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW     = $clog2(MAXLEN + 1);

    conv_state_e   state_q, state_d;
    logic          cont_q, notch50_q, arm_q;
    logic          arm_set, clr_req, start_req;
    logic          tload, tdone, store_ev, store;
    logic [CW-1:0] tlen, single_len, rep_len;
    logic [DW-1:0] res_data_q, thr_hi, thr_lo;
    logic          drdy_n_q;
    logic          unused_cfg;

    assign unused_cfg = ^{cfg_data_i[7], cfg_data_i[4]};

    // ---------------- configuration decode ----------------
    assign arm_set = cfg_wr_i && cfg_data_i[CFG_ONESHOT]
                     && (cfg_data_i[CFG_CYC_HI:CFG_CYC_LO] == 2'b00);
    assign clr_req = cfg_wr_i && cfg_data_i[CFG_CLR] && !cfg_data_i[CFG_ONESHOT]
                     && (cfg_data_i[CFG_CYC_HI:CFG_CYC_LO] == 2'b00);
    assign start_req = xfer_end_i && (arm_q || arm_set);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cont_q    <= 1'b0;
            notch50_q <= 1'b0;
            arm_q     <= 1'b0;
        end else begin
            if (cfg_wr_i) begin
                cont_q    <= cfg_data_i[CFG_CONT];
                notch50_q <= cfg_data_i[CFG_NOTCH50];
            end
            if (xfer_end_i) begin
                arm_q <= 1'b0;
            end else if (arm_set) begin
                arm_q <= 1'b1;
            end
        end
    end

    assign single_len = notch50_q ? CW'(ONE50)  : CW'(ONE60);
    assign rep_len    = notch50_q ? CW'(CONT50) : CW'(CONT60);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state / timer control ----------------
    always_comb begin
        state_d  = state_q;
        tload    = 1'b0;
        tlen     = single_len;
        store_ev = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (cont_q) begin
                    state_d = S_FIRST;
                    tload   = 1'b1;
                end else if (start_req) begin
                    state_d = S_SINGLE;
                    tload   = 1'b1;
                end
            end
            S_SINGLE: begin
                if (tdone) begin
                    store_ev = 1'b1;
                    state_d  = S_IDLE;
                end
            end
            S_FIRST, S_REPEAT: begin
                if (!cont_q) begin
                    state_d = S_IDLE;
                end else if (tdone) begin
                    store_ev = 1'b1;
                    state_d  = S_REPEAT;
                    tload    = 1'b1;
                    tlen     = rep_len;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    conv_timer #(.CW(CW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tload),
        .len_i  (tlen),
        .done_o (tdone)
    );

    // a pin fault suppresses the store
    assign store = store_ev && !pin_fault_i;

    // ---------------- output registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_data_q <= '0;
            drdy_n_q   <= 1'b1;
        end else begin
            if (store) begin
                res_data_q <= adc_sample_i;
                drdy_n_q   <= 1'b0;
            end else if (res_rd_i) begin
                drdy_n_q   <= 1'b1;
            end
        end
    end

    thr_regs #(.DW(DW)) u_thr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (thr_wr_i),
        .sel_i  (thr_sel_i),
        .data_i (thr_data_i),
        .hi_o   (thr_hi),
        .lo_o   (thr_lo)
    );

    fault_status #(.DW(DW)) u_fault (
        .clk         (clk),
        .rst_n       (rst_n),
        .store_i     (store),
        .sample_i    (adc_sample_i),
        .hi_i        (thr_hi),
        .lo_i        (thr_lo),
        .pin_fault_i (pin_fault_i),
        .clr_i       (clr_req),
        .status_o    (status_o)
    );

    assign result_o = {res_data_q, |status_o[7:2]};
    assign drdy_n_o = drdy_n_q;

endmodule

// File: rtl/rtd_conv_chk.sv
module rtd_conv_chk #(
    parameter int DW = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pin_fault_i,
    input logic          res_rd_i,
    input logic          store,
    input logic          clr_req,
    input logic [DW-1:0] adc_sample_i,
    input logic [DW-1:0] thr_hi,
    input logic [DW-1:0] thr_lo,
    input logic [DW-1:0] res_data_q,
    input logic [7:0]    status_o,
    input logic          drdy_n_o
);
    p_hi_inclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (store && (adc_sample_i >= thr_hi)) |=> status_o[7]);

    p_lo_inclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (store && (adc_sample_i <= thr_lo)) |=> status_o[6]);

    p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pin_fault_i |=> $stable(res_data_q));

    p_pin_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pin_fault_i |=> status_o[2]);

    p_no_ready_in_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_fault_i && drdy_n_o) |=> drdy_n_o);

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_req |=> ((status_o & $past(status_o)) == $past(status_o)));

    p_ready_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> !drdy_n_o);

    p_ready_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_rd_i && !store) |=> drdy_n_o);

endmodule

bind rtd_conv_ctrl rtd_conv_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_fault_i  (pin_fault_i),
    .res_rd_i     (res_rd_i),
    .store        (store),
    .clr_req      (clr_req),
    .adc_sample_i (adc_sample_i),
    .thr_hi       (thr_hi),
    .thr_lo       (thr_lo),
    .res_data_q   (res_data_q),
    .status_o     (status_o),
    .drdy_n_o     (drdy_n_o)
);

// File: tb/rtd_conv_ctrl_bench.sv
module rtd_conv_ctrl_bench;
    localparam int DW     = 15;
    localparam int ONE60  = 40;
    localparam int ONE50  = 52;
    localparam int CONT60 = 14;
    localparam int CONT50 = 18;

    // {notch50, high, low, sample, exp bit7, exp bit6}
    localparam int VN = 8;
    localparam logic [47:0] VEC [VN] = '{
        {1'b0, 15'h7FFF, 15'h0000, 15'h1000, 1'b0, 1'b0},
        {1'b1, 15'h1000, 15'h0000, 15'h1000, 1'b1, 1'b0},
        {1'b0, 15'h1001, 15'h0000, 15'h1000, 1'b0, 1'b0},
        {1'b1, 15'h7FFF, 15'h1000, 15'h1000, 1'b0, 1'b1},
        {1'b0, 15'h7FFF, 15'h0FFF, 15'h1000, 1'b0, 1'b0},
        {1'b1, 15'h7FFF, 15'h0000, 15'h0000, 1'b0, 1'b1},
        {1'b0, 15'h7FFF, 15'h0000, 15'h7FFF, 1'b1, 1'b0},
        {1'b1, 15'h0010, 15'h0020, 15'h0015, 1'b1, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [7:0]    cfg_data = '0;
    logic          thr_wr = 1'b0;
    logic          thr_sel = 1'b0;
    logic [DW:0]   thr_data = '0;
    logic          xfer_end = 1'b0;
    logic          res_rd = 1'b0;
    logic          pin_fault = 1'b0;
    logic [DW-1:0] sample = '0;
    logic [DW:0]   result;
    logic [7:0]    status;
    logic          drdy_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #2.5 clk = ~clk;

    rtd_conv_ctrl #(
        .DW(DW), .ONE60(ONE60), .ONE50(ONE50), .CONT60(CONT60), .CONT50(CONT50)
    ) u_rtd_conv_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr_i     (cfg_wr),
        .cfg_data_i   (cfg_data),
        .thr_wr_i     (thr_wr),
        .thr_sel_i    (thr_sel),
        .thr_data_i   (thr_data),
        .xfer_end_i   (xfer_end),
        .res_rd_i     (res_rd),
        .pin_fault_i  (pin_fault),
        .adc_sample_i (sample),
        .result_o     (result),
        .status_o     (status),
        .drdy_n_o     (drdy_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic cfg(input logic [7:0] b);
        cfg_wr = 1'b1; cfg_data = b;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic thr(input logic sel, input logic [DW-1:0] v);
        thr_wr = 1'b1; thr_sel = sel; thr_data = {v, 1'b1};
        @(negedge clk);
        thr_wr = 1'b0;
    endtask

    task automatic end_xfer();
        xfer_end = 1'b1;
        @(negedge clk);
        xfer_end = 1'b0;
    endtask

    task automatic rd();
        res_rd = 1'b1;
        @(negedge clk);
        res_rd = 1'b0;
    endtask

    // arm, release, and check the store lands exactly N edges after the start edge
    task automatic run_single(input logic f, input string tag);
        int n;
        n = f ? ONE50 : ONE60;
        cfg(8'h20 | {7'b0, f});
        end_xfer();
        repeat (n - 1) @(negedge clk);
        check({tag, " R3 ready not before end"}, drdy_n, 1);
        @(negedge clk);
        check({tag, " R9 ready falls on store"}, drdy_n, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 ready", drdy_n, 1);
        check("R1 status", status, 0);
        check("R1 result", result, 0);

        // R1 reset limits: full scale hits high only, zero hits low only
        sample = 15'h7FFF;
        run_single(1'b0, "R1a");
        check("R1 full scale status", status, 8'h80);
        rd();
        check("R9 ready rises after read", drdy_n, 1);
        cfg(8'h02);
        sample = 15'h0000;
        run_single(1'b0, "R1b");
        check("R1 zero status", status, 8'h40);
        rd();
        cfg(8'h02);

        // vector table: R5 R6 R3 R9
        for (int i = 0; i < VN; i++) begin
            logic f;
            logic e7, e6;
            f  = VEC[i][47];
            e7 = VEC[i][1];
            e6 = VEC[i][0];
            thr(1'b0, VEC[i][46:32]);
            thr(1'b1, VEC[i][31:17]);
            cfg(8'h02 | {7'b0, f});
            sample = VEC[i][16:2];
            run_single(f, "vec");
            check("R5 result layout", result, {VEC[i][16:2], e7 | e6});
            check("R6 limit compare", status, {e7, e6, 6'b0});
            repeat (3) @(negedge clk);
            check("R9 ready held until read", drdy_n, 0);
            rd();
            check("R9 ready rises after read", drdy_n, 1);
        end

        // R8 guarded clear: status is 0xC0 from the last vector
        cfg(8'h0A);
        check("R8 clear with cycle bit ignored", status, 8'hC0);
        cfg(8'h06);
        check("R8 clear with bit2 ignored", status, 8'hC0);
        cfg(8'h02);
        check("R8 clear accepted", status, 8'h00);
        check("R5 summary bit cleared", result[0], 0);

        // R2 arm held across a multi-byte write, start only on transaction end
        thr(1'b0, 15'h7FFF);
        thr(1'b1, 15'h0000);
        sample = 15'h0123;
        cfg(8'h20);
        repeat (ONE60 + 4) @(negedge clk);
        check("R2 no start without transaction end", drdy_n, 1);
        cfg(8'h00);
        end_xfer();
        repeat (ONE60 - 1) @(negedge clk);
        check("R2 not early", drdy_n, 1);
        @(negedge clk);
        check("R2 started on transaction end", drdy_n, 0);
        check("R2 result", result, {15'h0123, 1'b0});
        rd();

        // R10 re-arm during a running conversion is discarded
        cfg(8'h20);
        end_xfer();
        repeat (5) @(negedge clk);
        cfg(8'h20);
        end_xfer();
        repeat (ONE60 - 8) @(negedge clk);
        check("R10 first conversion not early", drdy_n, 1);
        @(negedge clk);
        check("R10 first conversion done", drdy_n, 0);
        rd();
        repeat (ONE60 + 4) @(negedge clk);
        check("R10 second request ignored", drdy_n, 1);

        // R7 pin fault freezes results
        pin_fault = 1'b1;
        @(negedge clk);
        check("R7 pin flag set", status, 8'h04);
        sample = 15'h0555;
        cfg(8'h20);
        end_xfer();
        repeat (ONE60 + 2) @(negedge clk);
        check("R7 no ready during fault", drdy_n, 1);
        check("R7 result frozen", result, {15'h0123, 1'b1});
        cfg(8'h02);
        check("R8 pin flag re-sets on clear", status, 8'h04);
        pin_fault = 1'b0;
        cfg(8'h02);
        check("R8 clear after fault gone", status, 8'h00);
        run_single(1'b0, "R7");
        check("R7 storing resumes", result, {15'h0555, 1'b0});
        rd();

        // R4 continuous mode, 60 Hz
        sample = 15'h0AAA;
        cfg(8'h40);
        repeat (ONE60) @(negedge clk);
        check("R4 first result not early", drdy_n, 1);
        @(negedge clk);
        check("R4 first result", drdy_n, 0);
        check("R4 first data", result, {15'h0AAA, 1'b0});
        rd();
        sample = 15'h0BBB;
        repeat (CONT60 - 2) @(negedge clk);
        check("R4 period not early", drdy_n, 1);
        @(negedge clk);
        check("R4 periodic result", drdy_n, 0);
        check("R4 periodic data", result, {15'h0BBB, 1'b0});
        rd();
        cfg(8'h00);
        repeat (2 * CONT60 + 4) @(negedge clk);
        check("R4 stop ends conversions", drdy_n, 1);

        // R4 continuous mode, 50 Hz
        sample = 15'h0CCC;
        cfg(8'h41);
        repeat (ONE50) @(negedge clk);
        check("R4 R3 first 50Hz not early", drdy_n, 1);
        @(negedge clk);
        check("R4 R3 first 50Hz result", drdy_n, 0);
        rd();
        repeat (CONT50 - 2) @(negedge clk);
        check("R4 50Hz period not early", drdy_n, 1);
        @(negedge clk);
        check("R4 50Hz periodic result", drdy_n, 0);
        rd();
        cfg(8'h00);
        repeat (2 * CONT50 + 4) @(negedge clk);
        check("R4 50Hz stop", drdy_n, 1);

        ended = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule